// File: doc/BRIEF.md
# Serial Channel Interrupt Identification and DMA Request Logic

This block collects the four status conditions of one asynchronous serial channel: line errors, a filled receive buffer, an emptied transmit buffer and a change on the modem handshake lines. Each condition has its own enable bit. The block turns the enabled conditions into a single interrupt line and a 3-bit identification code. The code reports the most urgent pending source, and its lowest bit is an active-low pending flag. The block also drives two DMA request lines, one for receive and one for transmit. The receive request is withheld whenever a line error is latched, so a damaged character is never moved by DMA.

The surrounding channel logic supplies single-cycle strobes. It pulses one when a character moves into the receive buffer, one when a character leaves the transmit buffer, and one for each error event. It also passes the read and write strobes of the registers that acknowledge each condition. The modem inputs are active low. When internal loopback is selected, change detection watches register-driven substitute values in place of the pins.

Top module: `uart_irq_dma`

## Requirements
- R1: After reset, intId reads 001, intReq and intPendN read 0 and 1, rxDmaReq reads 0 and txDmaReq reads 1 (the transmit buffer starts empty).
- R2: A pulse on any of errOverrun, errParity, errFraming or breakDet latches the line status condition from the next cycle. A rdLineStat pulse clears all latched errors.
- R3: A rxXfer pulse sets the receive-full condition from the next cycle. A rdRxBuf pulse clears it.
- R4: A txXfer pulse sets the transmit-empty interrupt condition from the next cycle. The condition is cleared by a wrTxBuf pulse. It is also cleared by a rdIntId pulse, but only in a cycle where intId bits 2:1 read 01.
- R5: With loopEn low, any change on a modemInN bit, compared against its value on the previous clock, sets the modem condition from the next cycle. A rdModemStat pulse clears it.
- R6: With loopEn high, loopModemN replaces modemInN as the watched value. A change caused by switching loopEn also counts as a change.
- R7: intId bits 2:1 give the highest-priority enabled active source: 11 line status, 10 receive full, 01 transmit empty, 00 modem. Priority runs in that order.
- R8: intEnable bit 0 enables line status, bit 1 receive full, bit 2 transmit empty and bit 3 modem. With no enabled source active, intId reads 001 and intReq reads 0. Otherwise intId bit 0 reads 0 and intReq reads 1. intPendN is always the inverse of intReq.
- R9: txDmaReq is 1 from the cycle after a txXfer until the cycle after a wrTxBuf, whatever intEnable holds and whether or not the interrupt was acknowledged.
- R10: rxDmaReq equals the receive-full condition, gated to 0 while any line error is latched. It is independent of intEnable.
- R11: When a set strobe and its clearing strobe arrive in the same cycle, the condition ends up set.
- R12: In the first clock after reset, the modem inputs are only sampled. Modem inputs that are already low at reset raise no modem condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| errOverrun | input | 1 | Overrun event strobe |
| errParity | input | 1 | Parity error event strobe |
| errFraming | input | 1 | Framing error event strobe |
| breakDet | input | 1 | Break detected strobe |
| rxXfer | input | 1 | Character moved into receive buffer |
| txXfer | input | 1 | Character moved out of transmit buffer |
| modemInN | input | 4 | Active-low modem handshake pins |
| loopEn | input | 1 | Select register-driven modem values |
| loopModemN | input | 4 | Register-driven modem substitute values |
| intEnable | input | 4 | Per-source interrupt enables |
| rdLineStat | input | 1 | Read strobe of the line status register |
| rdRxBuf | input | 1 | Read strobe of the receive buffer |
| rdModemStat | input | 1 | Read strobe of the modem status register |
| rdIntId | input | 1 | Read strobe of the identification register |
| wrTxBuf | input | 1 | Write strobe of the transmit buffer |
| intPendN | output | 1 | Active-low interrupt pending flag |
| intId | output | 3 | Identification code, bit 0 = intPendN |
| intReq | output | 1 | Interrupt request line |
| rxDmaReq | output | 1 | Receive DMA request |
| txDmaReq | output | 1 | Transmit DMA request |

## Verification
The bench goes after the case where an identification read happens while the transmit source is hidden behind a higher-priority one. A design that clears regardless of the reported source would silently lose the transmit interrupt. The bench also fires set and clear strobes in the same cycle, where a clear-wins design drops a fresh event. It latches an error under a full receive buffer, where a design without the gating would let DMA carry the damaged character. Further cases are a loopback toggle with differing pin and substitute values, which a pin-only detector misses, and modem pins held low through reset, where an unprimed comparator raises a false modem interrupt.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC  = 4;
  localparam int SRC_LINE = 0;
  localparam int SRC_RX   = 1;
  localparam int SRC_TX   = 2;
  localparam int SRC_MDM  = 3;

  typedef struct packed {
    logic clrLine;
    logic clrRxFull;
    logic clrTxInt;
    logic clrTxBuf;
    logic clrModem;
  } clrStrobes_t;
endpackage

// File: rtl/uirq_datapath.sv
module uirq_datapath
  import uart_irq_pkg::*;
#(
  parameter int NUM_ERR   = 4,
  parameter int NUM_MODEM = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_ERR-1:0]   errEvents,
  input  logic                 rxXfer,
  input  logic                 txXfer,
  input  logic [NUM_MODEM-1:0] modemInN,
  input  logic                 loopEn,
  input  logic [NUM_MODEM-1:0] loopModemN,
  input  clrStrobes_t          strobes,
  output logic [NUM_SRC-1:0]   srcActive,
  output logic                 rxDmaReq,
  output logic                 txDmaReq
);
  logic [NUM_ERR-1:0]   errFlags;
  logic [NUM_MODEM-1:0] modemSel;
  logic [NUM_MODEM-1:0] modemPrev;
  logic [NUM_MODEM-1:0] modemDiff;
  logic                 primed;
  logic                 modemFlag;
  logic                 rxFull;
  logic                 txBufEmpty;
  logic                 txIntFlag;
  logic                 lineActive;

  // one sticky flag per error kind; a new event wins over the clear
  for (genvar e = 0; e < NUM_ERR; e++) begin : g_err
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 errFlags[e] <= 1'b0;
      else if (errEvents[e])     errFlags[e] <= 1'b1;
      else if (strobes.clrLine)  errFlags[e] <= 1'b0;
    end
  end

  assign lineActive = |errFlags;

  // watched modem value: pins or register substitutes
  for (genvar m = 0; m < NUM_MODEM; m++) begin : g_mdm
    assign modemSel[m]  = loopEn ? loopModemN[m] : modemInN[m];
    assign modemDiff[m] = modemSel[m] ^ modemPrev[m];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) modemPrev[m] <= 1'b1;
      else       modemPrev[m] <= modemSel[m];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      modemFlag <= 1'b0;
    else if (primed && |modemDiff)  modemFlag <= 1'b1;
    else if (strobes.clrModem)      modemFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   rxFull <= 1'b0;
    else if (rxXfer)             rxFull <= 1'b1;
    else if (strobes.clrRxFull)  rxFull <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  txBufEmpty <= 1'b1;
    else if (txXfer)            txBufEmpty <= 1'b1;
    else if (strobes.clrTxBuf)  txBufEmpty <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  txIntFlag <= 1'b0;
    else if (txXfer)            txIntFlag <= 1'b1;
    else if (strobes.clrTxInt)  txIntFlag <= 1'b0;
  end

  always_comb begin
    srcActive           = '0;
    srcActive[SRC_LINE] = lineActive;
    srcActive[SRC_RX]   = rxFull;
    srcActive[SRC_TX]   = txIntFlag;
    srcActive[SRC_MDM]  = modemFlag;
  end

  assign rxDmaReq = rxFull & ~lineActive;
  assign txDmaReq = txBufEmpty;
endmodule

// File: rtl/uirq_control.sv
module uirq_control
  import uart_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] srcActive,
  input  logic [NUM_SRC-1:0] intEnable,
  input  logic               rdLineStat,
  input  logic               rdRxBuf,
  input  logic               rdModemStat,
  input  logic               rdIntId,
  input  logic               wrTxBuf,
  output clrStrobes_t        strobes,
  output logic [2:0]         intId,
  output logic               intReq
);
  localparam int SEL_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] enabledSrc;
  logic [SEL_W-1:0]   winner;
  logic               anyPending;

  assign enabledSrc = srcActive & intEnable;
  assign anyPending = |enabledSrc;

  // fixed priority: lowest source index wins
  always_comb begin
    winner = SEL_W'(NUM_SRC - 1);
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (enabledSrc[i]) winner = SEL_W'(i);
    end
  end

  always_comb begin
    if (anyPending) intId = {~winner[1:0], 1'b0};
    else            intId = 3'b001;
  end

  assign intReq = anyPending;

  always_comb begin
    strobes.clrLine   = rdLineStat;
    strobes.clrRxFull = rdRxBuf;
    strobes.clrModem  = rdModemStat;
    strobes.clrTxBuf  = wrTxBuf;
    strobes.clrTxInt  = wrTxBuf |
                        (rdIntId && anyPending && (winner == SEL_W'(SRC_TX)));
  end
endmodule

// File: rtl/uart_irq_dma.sv
module uart_irq_dma
  import uart_irq_pkg::*;
#(
  parameter int NUM_MODEM = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 errOverrun,
  input  logic                 errParity,
  input  logic                 errFraming,
  input  logic                 breakDet,
  input  logic                 rxXfer,
  input  logic                 txXfer,
  input  logic [NUM_MODEM-1:0] modemInN,
  input  logic                 loopEn,
  input  logic [NUM_MODEM-1:0] loopModemN,
  input  logic [NUM_SRC-1:0]   intEnable,
  input  logic                 rdLineStat,
  input  logic                 rdRxBuf,
  input  logic                 rdModemStat,
  input  logic                 rdIntId,
  input  logic                 wrTxBuf,
  output logic                 intPendN,
  output logic [2:0]           intId,
  output logic                 intReq,
  output logic                 rxDmaReq,
  output logic                 txDmaReq
);
  localparam int NUM_ERR = 4;

  clrStrobes_t        strobes;
  logic [NUM_SRC-1:0] srcActive;
  logic [NUM_ERR-1:0] errEvents;

  assign errEvents = {breakDet, errFraming, errParity, errOverrun};

  uirq_datapath #(.NUM_ERR(NUM_ERR), .NUM_MODEM(NUM_MODEM)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .errEvents  (errEvents),
    .rxXfer     (rxXfer),
    .txXfer     (txXfer),
    .modemInN   (modemInN),
    .loopEn     (loopEn),
    .loopModemN (loopModemN),
    .strobes    (strobes),
    .srcActive  (srcActive),
    .rxDmaReq   (rxDmaReq),
    .txDmaReq   (txDmaReq)
  );

  uirq_control i_control (
    .srcActive   (srcActive),
    .intEnable   (intEnable),
    .rdLineStat  (rdLineStat),
    .rdRxBuf     (rdRxBuf),
    .rdModemStat (rdModemStat),
    .rdIntId     (rdIntId),
    .wrTxBuf     (wrTxBuf),
    .strobes     (strobes),
    .intId       (intId),
    .intReq      (intReq)
  );

  assign intPendN = intId[0];
endmodule

// File: rtl/uart_irq_dma_checker.sv
module uart_irq_dma_checker (
  input logic       clk,
  input logic       rstN,
  input logic       errOverrun,
  input logic       errParity,
  input logic       errFraming,
  input logic       breakDet,
  input logic       txXfer,
  input logic [3:0] intEnable,
  input logic       intPendN,
  input logic [2:0] intId,
  input logic       intReq,
  input logic       rxDmaReq,
  input logic       txDmaReq
);
  logic anyErr;
  assign anyErr = errOverrun | errParity | errFraming | breakDet;

  assert_rx_dma_blocked_R10: assert property (@(posedge clk) disable iff (!rstN)
    anyErr |=> !rxDmaReq);

  assert_tx_dma_after_xfer_R9: assert property (@(posedge clk) disable iff (!rstN)
    txXfer |=> txDmaReq);

  assert_line_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    anyErr |=> (!intEnable[0] || intId == 3'b110));

  assert_idle_code_R8: assert property (@(posedge clk) disable iff (!rstN)
    !intReq |-> intId == 3'b001);

  assert_pend_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> (!intPendN && !intId[0]));
endmodule

bind uart_irq_dma uart_irq_dma_checker i_checker (
  .clk        (clk),
  .rstN       (rstN),
  .errOverrun (errOverrun),
  .errParity  (errParity),
  .errFraming (errFraming),
  .breakDet   (breakDet),
  .txXfer     (txXfer),
  .intEnable  (intEnable),
  .intPendN   (intPendN),
  .intId      (intId),
  .intReq     (intReq),
  .rxDmaReq   (rxDmaReq),
  .txDmaReq   (txDmaReq)
);

// File: tb/test_uart_irq_dma.sv
module test_uart_irq_dma;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       errOverrun = 0, errParity = 0, errFraming = 0, breakDet = 0;
  logic       rxXfer = 0, txXfer = 0;
  logic [3:0] modemInN = 4'hF;
  logic       loopEn = 0;
  logic [3:0] loopModemN = 4'hF;
  logic [3:0] intEnable = 4'h0;
  logic       rdLineStat = 0, rdRxBuf = 0, rdModemStat = 0, rdIntId = 0, wrTxBuf = 0;
  logic       intPendN, intReq, rxDmaReq, txDmaReq;
  logic [2:0] intId;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model state
  logic [3:0] mErr;
  logic       mRx, mTxBuf, mTxInt, mModem, mPrimed;
  logic [3:0] mPrev;

  uart_irq_dma i_uart_irq_dma (.*);

  always #10 clk = ~clk;   // 50 MHz

  function automatic logic [2:0] expId(logic [3:0] act, logic [3:0] en);
    logic [3:0] a;
    a = act & en;
    if (a[0]) return 3'b110;
    if (a[1]) return 3'b100;
    if (a[2]) return 3'b010;
    if (a[3]) return 3'b000;
    return 3'b001;
  endfunction

  function automatic logic [3:0] mAct();
    return {mModem, mTxInt, mRx, |mErr};
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    logic [2:0] e;
    e = expId(mAct(), intEnable);
    check(intId == e, {tag, " R7 intId"}, intId, e);
    check(intReq == (e != 3'b001) && intPendN == !intReq, {tag, " R8 intReq"}, intReq, e != 3'b001);
    check(txDmaReq == mTxBuf, {tag, " R9 txDmaReq"}, txDmaReq, mTxBuf);
    check(rxDmaReq == (mRx & ~|mErr), {tag, " R10 rxDmaReq"}, rxDmaReq, mRx & ~|mErr);
  endtask

  task automatic modelReset();
    mErr = 0; mRx = 0; mTxBuf = 1; mTxInt = 0; mModem = 0; mPrimed = 0; mPrev = 4'hF;
  endtask

  // inputs already driven; advance one clock and compare at negedge
  task automatic step(string tag);
    logic [3:0] ev, sel, nErr, nPrev;
    logic nRx, nTxBuf, nTxInt, nModem, txClr;
    ev    = {breakDet, errFraming, errParity, errOverrun};
    nErr  = ev | (mErr & {4{!rdLineStat}});
    nRx   = rxXfer | (mRx & !rdRxBuf);
    nTxBuf = txXfer | (mTxBuf & !wrTxBuf);
    txClr = wrTxBuf | (rdIntId && expId(mAct(), intEnable) == 3'b010);
    nTxInt = txXfer | (mTxInt & !txClr);
    sel   = loopEn ? loopModemN : modemInN;
    nModem = (mPrimed && sel != mPrev) | (mModem & !rdModemStat);
    nPrev = sel;
    @(posedge clk);
    @(negedge clk);
    mErr = nErr; mRx = nRx; mTxBuf = nTxBuf; mTxInt = nTxInt;
    mModem = nModem; mPrev = nPrev; mPrimed = 1;
    compareAll(tag);
  endtask

  task automatic clearPulses();
    {errOverrun, errParity, errFraming, breakDet, rxXfer, txXfer} = '0;
    {rdLineStat, rdRxBuf, rdModemStat, rdIntId, wrTxBuf} = '0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    // R12: modem pins low through reset must not raise a modem event
    modemInN = 4'b0101;
    intEnable = 4'hF;
    modelReset();
    repeat (3) @(negedge clk);
    check(intId == 3'b001 && !intReq && intPendN, "R1 reset intId", intId, 1);
    check(txDmaReq && !rxDmaReq, "R1 reset dma", {txDmaReq, rxDmaReq}, 2'b10);
    rstN = 1'b1;
    step("R12 prime");
    step("R12 hold");
    check(intId == 3'b001, "R12 no modem event after reset", intId, 1);

    // R2: each error kind latches, read clears
    for (int k = 0; k < 4; k++) begin
      {breakDet, errFraming, errParity, errOverrun} = 4'(1 << k);
      step("R2 set");
      clearPulses();
      check(intId == 3'b110, "R2 line status latched", intId, 3'b110);
      rdLineStat = 1; step("R2 clear"); clearPulses();
    end

    // R3 / R10: rx full then error masks DMA
    rxXfer = 1; step("R3 set"); clearPulses();
    check(rxDmaReq && intId == 3'b100, "R3 rx full", {rxDmaReq, intId}, 4'b1100);
    errParity = 1; step("R10 mask"); clearPulses();
    check(!rxDmaReq, "R10 rx dma blocked by error", rxDmaReq, 0);
    rdLineStat = 1; step("R10 unmask"); clearPulses();
    check(rxDmaReq, "R10 rx dma restored", rxDmaReq, 1);
    rdRxBuf = 1; step("R3 clear"); clearPulses();

    // R4: id read while tx hidden behind rx keeps tx
    wrTxBuf = 1; step("R9 fill"); clearPulses();
    check(!txDmaReq, "R9 tx dma low after write", txDmaReq, 0);
    txXfer = 1; rxXfer = 1; step("R4 setup"); clearPulses();
    rdIntId = 1; step("R4 hidden read"); clearPulses();
    rdRxBuf = 1; step("R4 rx gone"); clearPulses();
    check(intId == 3'b010, "R4 tx survives hidden id read", intId, 3'b010);
    rdIntId = 1; step("R4 id read clears"); clearPulses();
    check(intId == 3'b001 && txDmaReq, "R4 tx int cleared, R9 dma stays", {intId, txDmaReq}, 4'b0011);

    // R11: set and clear in same cycle
    rxXfer = 1; rdRxBuf = 1; errFraming = 1; rdLineStat = 1; step("R11 both"); clearPulses();
    check(intId == 3'b110 && !rxDmaReq, "R11 set wins", intId, 3'b110);
    rdLineStat = 1; rdRxBuf = 1; step("R11 cleanup"); clearPulses();

    // R5 / R6: pin change, then loopback
    modemInN = 4'b0100; step("R5 pin change");
    check(intId == 3'b000, "R5 modem change", intId, 0);
    rdModemStat = 1; step("R5 clear"); clearPulses();
    loopModemN = 4'b1111; loopEn = 1; step("R6 switch");
    check(intId == 3'b000, "R6 switch to loopback counts", intId, 0);
    rdModemStat = 1; step("R6 clear"); clearPulses();
    modemInN = 4'b0000; step("R6 pins ignored");
    check(intId == 3'b001, "R6 pins ignored in loopback", intId, 1);
    loopModemN = 4'b1110; step("R6 loop change");
    check(intId == 3'b000, "R6 loop value change", intId, 0);
    rdModemStat = 1; step("R6 clear2"); clearPulses();

    // R8: masking
    intEnable = 4'h0; txXfer = 1; step("R8 masked"); clearPulses();
    check(!intReq && intId == 3'b001, "R8 masked source gives no interrupt", intReq, 0);
    intEnable = 4'b0100; #1;
    check(intReq && intId == 3'b010, "R8 enable shows pending", intId, 3'b010);
    intEnable = 4'hF;

    // random phase
    for (int n = 0; n < 3000; n++) begin
      errOverrun  = ($urandom % 24) == 0;
      errParity   = ($urandom % 24) == 0;
      errFraming  = ($urandom % 24) == 0;
      breakDet    = ($urandom % 24) == 0;
      rxXfer      = ($urandom % 6) == 0;
      txXfer      = ($urandom % 6) == 0;
      rdLineStat  = ($urandom % 4) == 0;
      rdRxBuf     = ($urandom % 4) == 0;
      rdModemStat = ($urandom % 4) == 0;
      rdIntId     = ($urandom % 3) == 0;
      wrTxBuf     = ($urandom % 5) == 0;
      if (($urandom % 10) == 0) modemInN[$urandom % 4] ^= 1'b1;
      if (($urandom % 10) == 0) loopModemN[$urandom % 4] ^= 1'b1;
      if (($urandom % 50) == 0) loopEn = ~loopEn;
      if (($urandom % 40) == 0) intEnable = 4'($urandom);
      step("random");
    end
    clearPulses();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule